// File: doc/BRIEF.md
# Speech ROM Playback Sequencer

This block is the control sequencer of a delta-coded speech synthesizer. A start strobe and a 6-bit word number begin a run. The block first reads a two-byte pointer from a table in a byte-wide ROM. It then reads two-byte control words. Each control word gives the start of a run of delta data, a voiced flag, a stop flag and a repeat count. For every pitch period of 128 cycles, the block walks the delta data two bits at a time and keeps a 4-bit output level. When the repeat count runs out, it either fetches the next control word or returns to idle.

The ROM is read synchronously. The byte for the address driven in one cycle arrives on the data input in the next cycle. There is one clock domain and one state step per clock. A start strobe restarts the sequence from any state.

Top module: `spk_seq`

## Requirements
- R1: After reset, and in every idle cycle, busy is low, the ROM address is 0 and the level is 0. Without a start strobe the block stays idle.
- R2: A start strobe in any state, idle included, makes the next cycle the first pointer-fetch cycle. This transition overrides every other one. While start is held, the block stays in that first cycle.
- R3: The pointer fetch takes three cycles. The first cycle drives address word*4 and the second drives word*4+1. In the third, the word address {0, b0[7:5], b1} is driven at once, where b0 and b1 are the two table bytes. The third cycle combines the stored upper nibble with the byte that is arriving.
- R4: A control word at word address W is decoded from its first byte c: bit 1 is voiced, bit 2 is stop, and the inverse of bits 4:3 is the initial repeat count. The next cycle drives W+1. The delta data then starts at byte address {0, c[7:5], d}, where d is the second byte, and this address is driven in the same cycle that d arrives.
- R5: In the first play cycle of a control word the level is exactly 1000 (8). The next control word is fetched from W+2.
- R6: In play, a 14-bit delta pointer moves one delta per cycle. Its upper 12 bits are the byte address and its low 2 bits select the delta. The delta used in a cycle is data bits [2s+1:2s], where s is the select of the address driven in the previous cycle. The pointer moves upward. When voiced is set, the pointer moves upward for 64 cycles and then downward for 64 cycles in each period.
- R7: In a play cycle followed by another play cycle, the level changes by a delta code: 00 gives -3, 01 gives -1, 10 gives +1 and 11 gives +3, saturating at 0 and 15. When play is left, the level is cleared.
- R8: A pitch period is 128 cycles. The number of periods per control word is 4 minus the repeat field value. After the last period, the block goes idle if stop is set; otherwise it fetches the next control word, and the last play cycle already drives its address.
- R9: Busy is high in every state except idle. Busy rises only after a start strobe.
- R10: A start strobe that falls in the cycle where the final period of a stop-flagged control word ends still restarts the block. Busy stays high and the next address is the new table entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start / restart strobe |
| word_i | input | 6 | Word number to speak |
| rom_data_i | input | 8 | ROM byte for the address driven in the previous cycle |
| busy_o | output | 1 | High while a word is being processed |
| rom_addr_o | output | 12 | ROM byte address |
| level_o | output | 4 | Output level register |

## Verification
The case of interest is a restart strobe that falls in the same cycle as a pitch-period carry. This matters most on the last repeat of a stop-flagged control word, where the carry alone would send the block to idle. The bench waits until its own model reaches the final cycle of the final period, asserts start with a new word number in exactly that cycle, and checks the result. It expects busy to stay high, the next address to be the new table entry, and the full busy length of the new word to follow. A restart in the middle of a period, and a start held for two cycles, are checked in the same way against the model.

// File: rtl/spk_seq_pkg.sv
package spk_seq_pkg;

    // Fixed ROM byte format and address layout.
    localparam int ADDR_W = 12;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 6;
    localparam int SEL_W  = 2;
    localparam int PTR_W  = ADDR_W + SEL_W;
    localparam int HI_W   = ADDR_W - BYTE_W;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PTR  = 3'd1,
        ST_WHI  = 3'd2,
        ST_WLO  = 3'd3,
        ST_CTL  = 3'd4,
        ST_DLO  = 3'd5,
        ST_PLAY = 3'd6
    } seq_st_e;

    typedef struct packed {
        logic            voiced;
        logic            stop;
        logic [1:0]      rep_init;
        logic [HI_W-1:0] hi;
    } ctl_fields_t;

    // R4: field positions of the first control byte
    function automatic ctl_fields_t decode_ctl(logic [BYTE_W-1:0] b);
        ctl_fields_t f;
        f.voiced   = b[1];
        f.stop     = b[2];
        f.rep_init = ~b[4:3];
        f.hi       = {1'b0, b[7:5]};
        return f;
    endfunction

    // R7: delta code to saturated level
    function automatic int lvl_step(int lvl, logic [1:0] code, int maxv);
        int v;
        case (code)
            2'b00:   v = lvl - 3;
            2'b01:   v = lvl - 1;
            2'b10:   v = lvl + 1;
            default: v = lvl + 3;
        endcase
        if (v < 0)    v = 0;
        if (v > maxv) v = maxv;
        return v;
    endfunction

endpackage

// File: rtl/spk_seq_ctl.sv
module spk_seq_ctl
    import spk_seq_pkg::*;
#(
    parameter int PPC_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             voiced_i,
    input  logic             stop_i,
    input  logic [1:0]       rep_i,
    output seq_st_e          st_q,
    output seq_st_e          st_n,
    output logic [PPC_W-1:0] ppc_q,
    output logic             voiced_q,
    output logic             carry_o
);
    logic [1:0] rep_q;
    logic       stop_q;

    assign carry_o = (st_q == ST_PLAY) && (&ppc_q);

    // R2: restart overrides everything; R8: period end decisions
    always_comb begin
        st_n = ST_IDLE;
        if (start_i) begin
            st_n = ST_PTR;
        end else begin
            case (st_q)
                ST_IDLE: st_n = ST_IDLE;
                ST_PTR:  st_n = ST_WHI;
                ST_WHI:  st_n = ST_WLO;
                ST_WLO:  st_n = ST_CTL;
                ST_CTL:  st_n = ST_DLO;
                ST_DLO:  st_n = ST_PLAY;
                ST_PLAY: begin
                    if (carry_o && (&rep_q)) st_n = stop_q ? ST_IDLE : ST_CTL;
                    else                     st_n = ST_PLAY;
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ppc_q    <= '0;
            rep_q    <= '0;
            stop_q   <= 1'b0;
            voiced_q <= 1'b0;
        end else begin
            st_q <= st_n;
            case (st_q)
                ST_CTL: begin
                    voiced_q <= voiced_i;
                    stop_q   <= stop_i;
                    rep_q    <= rep_i;
                end
                ST_DLO:  ppc_q <= '0;
                ST_PLAY: begin
                    ppc_q <= ppc_q + 1'b1;
                    if (carry_o) rep_q <= rep_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spk_seq_addr.sv
module spk_seq_addr
    import spk_seq_pkg::*;
#(
    parameter int PPC_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           st_q,
    input  seq_st_e           st_n,
    input  logic [WORD_W-1:0] word_i,
    input  logic [BYTE_W-1:0] rom_i,
    input  logic [HI_W-1:0]   hi_i,
    input  logic [PPC_W-1:0]  ppc_i,
    input  logic              voiced_i,
    input  logic              carry_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [SEL_W-1:0]  sel_o
);
    localparam logic [PPC_W-1:0] TURN = PPC_W'((1 << (PPC_W - 1)) - 1);

    logic [ADDR_W-1:0] war_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              up_q;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] byte_addr;

    assign tbl_addr  = {{(ADDR_W - WORD_W - 2){1'b0}}, word_i, 2'b00};
    assign byte_addr = ptr_q[PTR_W-1:SEL_W];

    // R3/R4/R6: address source per state
    always_comb begin
        case (st_q)
            ST_PTR:  addr_o = tbl_addr;
            ST_WHI:  addr_o = byte_addr + ADDR_W'(1);
            ST_WLO:  addr_o = {war_q[ADDR_W-1 -: HI_W], rom_i};
            ST_CTL:  addr_o = war_q + ADDR_W'(1);
            ST_DLO:  addr_o = {ptr_q[PTR_W-1 -: HI_W], rom_i};
            ST_PLAY: addr_o = (st_n == ST_CTL) ? war_q : byte_addr;
            default: addr_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            war_q <= '0;
            ptr_q <= '0;
            up_q  <= 1'b1;
            sel_o <= '0;
        end else begin
            case (st_q)
                ST_PTR: ptr_q <= {tbl_addr, {SEL_W{1'b0}}};
                ST_WHI: begin
                    war_q[ADDR_W-1 -: HI_W] <= hi_i;
                    ptr_q[PTR_W-1:SEL_W]    <= byte_addr + ADDR_W'(1);
                end
                ST_WLO: war_q[BYTE_W-1:0] <= rom_i;
                ST_CTL: begin
                    ptr_q[PTR_W-1 -: HI_W] <= hi_i;
                    war_q                  <= war_q + ADDR_W'(1);
                end
                ST_DLO: begin
                    ptr_q[BYTE_W+SEL_W-1:0] <= {rom_i, {SEL_W{1'b0}}};
                    war_q                   <= war_q + ADDR_W'(1);
                    up_q                    <= 1'b1;
                    sel_o                   <= '0;
                end
                ST_PLAY: begin
                    ptr_q <= up_q ? ptr_q + PTR_W'(1) : ptr_q - PTR_W'(1);
                    sel_o <= ptr_q[SEL_W-1:0];
                    if (carry_i)                        up_q <= 1'b1;
                    else if (voiced_i && ppc_i == TURN) up_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spk_seq_level.sv
module spk_seq_level
    import spk_seq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_st_e           st_q,
    input  seq_st_e           st_n,
    input  logic [BYTE_W-1:0] rom_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [LVL_W-1:0]  level_o
);
    localparam int               LVL_MAX = (1 << LVL_W) - 1;
    localparam logic [LVL_W-1:0] LVL_MID = LVL_W'(1 << (LVL_W - 1));

    logic [1:0] code;
    assign code = rom_i[{sel_i, 1'b0} +: 2];

    always_ff @(posedge clk) begin
        if (rst) begin
            level_o <= '0;
        end else if (st_q == ST_DLO) begin
            level_o <= LVL_MID;
        end else if (st_q == ST_PLAY && st_n == ST_PLAY) begin
            level_o <= LVL_W'(lvl_step(int'(level_o), code, LVL_MAX));
        end else begin
            level_o <= '0;
        end
    end

endmodule

// File: rtl/spk_seq.sv
module spk_seq
    import spk_seq_pkg::*;
#(
    parameter int PPC_W = 7,
    parameter int LVL_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [BYTE_W-1:0] rom_data_i,
    output logic              busy_o,
    output logic [ADDR_W-1:0] rom_addr_o,
    output logic [LVL_W-1:0]  level_o
);
    seq_st_e          st_q;
    seq_st_e          st_n;
    logic [PPC_W-1:0] ppc;
    logic             voiced;
    logic             carry;
    logic [SEL_W-1:0] sel;
    ctl_fields_t      cf;

    assign cf     = decode_ctl(rom_data_i);
    assign busy_o = (st_q != ST_IDLE);   // R9

    spk_seq_ctl #(.PPC_W(PPC_W)) u_ctl (
        .clk(clk), .rst(rst), .start_i(start_i),
        .voiced_i(cf.voiced), .stop_i(cf.stop), .rep_i(cf.rep_init),
        .st_q(st_q), .st_n(st_n), .ppc_q(ppc), .voiced_q(voiced), .carry_o(carry)
    );

    spk_seq_addr #(.PPC_W(PPC_W)) u_addr (
        .clk(clk), .rst(rst), .st_q(st_q), .st_n(st_n),
        .word_i(word_i), .rom_i(rom_data_i), .hi_i(cf.hi),
        .ppc_i(ppc), .voiced_i(voiced), .carry_i(carry),
        .addr_o(rom_addr_o), .sel_o(sel)
    );

    spk_seq_level #(.LVL_W(LVL_W)) u_lvl (
        .clk(clk), .rst(rst), .st_q(st_q), .st_n(st_n),
        .rom_i(rom_data_i), .sel_i(sel), .level_o(level_o)
    );

endmodule

// File: rtl/spk_seq_chk.sv
module spk_seq_chk
    import spk_seq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              busy_o,
    input logic [ADDR_W-1:0] rom_addr_o,
    input logic [LVL_W-1:0]  level_o,
    input seq_st_e           st_q,
    input seq_st_e           st_n,
    input logic              carry
);
    localparam logic [LVL_W-1:0] MID = LVL_W'(1 << (LVL_W - 1));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (rom_addr_o == '0 && level_o == '0));

    a_r2_restart: assert property (@(posedge clk) disable iff (rst)
        start_i |=> st_q == ST_PTR);

    a_r3_ptr_second_byte: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PTR && !start_i) |=> rom_addr_o == $past(rom_addr_o) + ADDR_W'(1));

    a_r4_ctl_second_byte: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_WLO && !start_i) |=> rom_addr_o == $past(rom_addr_o) + ADDR_W'(1));

    a_r5_level_entry: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_DLO |=> level_o == MID);

    a_r6_addr_walk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PLAY && st_n == ST_PLAY) |=>
            (st_n == ST_CTL || rom_addr_o == $past(rom_addr_o) ||
             rom_addr_o == $past(rom_addr_o) + ADDR_W'(1) ||
             rom_addr_o == $past(rom_addr_o) - ADDR_W'(1)));

    a_r7_level_step: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_PLAY && st_n == ST_PLAY) |=>
            ((int'(level_o) - int'($past(level_o)) <= 3) &&
             (int'(level_o) - int'($past(level_o)) >= -3)));

    a_r8_end_on_carry: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> ($past(carry) && !$past(start_i)));

    a_r9_busy_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

endmodule

bind spk_seq spk_seq_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .rom_addr_o(rom_addr_o), .level_o(level_o),
    .st_q(st_q), .st_n(st_n), .carry(carry)
);

// File: tb/sim_spk_seq.sv
module sim_spk_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] word = '0;
    logic [7:0] rom_q = '0;
    logic       busy;
    logic [11:0] addr;
    logic [3:0] lvl;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    spk_seq u0 (
        .clk(clk), .rst(rst), .start_i(start), .word_i(word),
        .rom_data_i(rom_q), .busy_o(busy), .rom_addr_o(addr), .level_o(lvl)
    );

    int mem[int];

    function automatic int rd(int a);
        if (mem.exists(a)) return mem[a];
        return (a * 73 + (a >> 4)) & 255;
    endfunction

    always @(posedge clk) rom_q <= 8'(rd(int'(addr)));

    // behavioural reference model
    int m_st = 0, m_war = 0, m_ptr = 0, m_up = 1, m_sel = 0;
    int m_ppc = 0, m_rep = 0, m_stop = 0, m_voi = 0, m_lvl = 0;

    function automatic int nxt();
        if (start) return 1;
        case (m_st)
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 5;
            5: return 6;
            6: begin
                if (m_ppc == 127 && m_rep == 3) return m_stop ? 0 : 4;
                return 6;
            end
            default: return 0;
        endcase
    endfunction

    function automatic int lstep(int l, int c);
        int v;
        v = l + ((c == 0) ? -3 : (c == 1) ? -1 : (c == 2) ? 1 : 3);
        if (v < 0) v = 0;
        if (v > 15) v = 15;
        return v;
    endfunction

    function automatic int exp_addr();
        int r;
        r = int'(rom_q);
        case (m_st)
            1: return int'(word) * 4;
            2: return ((m_ptr >> 2) + 1) & 'hFFF;
            3: return (m_war & 'hF00) | r;
            4: return (m_war + 1) & 'hFFF;
            5: return (((m_ptr >> 10) & 15) << 8) | r;
            6: return (nxt() == 4) ? m_war : (m_ptr >> 2);
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int ns;
        int r;
        if (rst) begin
            m_st = 0; m_war = 0; m_ptr = 0; m_up = 1; m_sel = 0;
            m_ppc = 0; m_rep = 0; m_stop = 0; m_voi = 0; m_lvl = 0;
        end else begin
            ns = nxt();
            r  = int'(rom_q);
            case (m_st)
                1: m_ptr = int'(word) * 16;
                2: begin
                    m_war = (((r >> 5) & 7) << 8) | (m_war & 'hFF);
                    m_ptr = (m_ptr + 4) & 'h3FFF;
                end
                3: m_war = (m_war & 'hF00) | r;
                4: begin
                    m_voi  = (r >> 1) & 1;
                    m_stop = (r >> 2) & 1;
                    m_rep  = 3 - ((r >> 3) & 3);
                    m_ptr  = (m_ptr & 'h3FF) | (((r >> 5) & 7) << 10);
                    m_war  = (m_war + 1) & 'hFFF;
                end
                5: begin
                    m_ptr = (m_ptr & 'h3C00) | (r << 2);
                    m_war = (m_war + 1) & 'hFFF;
                    m_up  = 1; m_sel = 0; m_ppc = 0;
                end
                6: begin
                    m_lvl = (ns == 6) ? lstep(m_lvl, (r >> (2 * m_sel)) & 3) : 0;
                    m_sel = m_ptr & 3;
                    m_ptr = (m_up != 0 ? m_ptr + 1 : m_ptr - 1) & 'h3FFF;
                    if (m_ppc == 127) begin
                        m_rep = (m_rep + 1) & 3;
                        m_up  = 1;
                    end else if (m_voi != 0 && m_ppc == 63) begin
                        m_up = 0;
                    end
                    m_ppc = (m_ppc + 1) & 127;
                end
                default: ;
            endcase
            if (m_st == 5) m_lvl = 8;
            else if (m_st != 6) m_lvl = 0;
            m_st = ns;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string addr_tag();
        case (m_st)
            0:       return "R1 idle address";
            1, 2, 3: return "R3 pointer address";
            4, 5:    return "R4 control/data-start address";
            default: return "R6 play address";
        endcase
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #2;
        if (!rst) begin
            chk(busy == (m_st != 0), "R9 busy", int'(busy), int'(m_st != 0));
            chk(int'(addr) == exp_addr(), addr_tag(), int'(addr), exp_addr());
            chk(int'(lvl) == m_lvl, (m_st == 6) ? "R7 level" : "R5 level",
                int'(lvl), m_lvl);
        end
    end

    task automatic fire(int w);
        @(negedge clk);
        start = 1'b1;
        word  = 6'(w);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic count_busy(int exp_n, string tag);
        int n;
        n = 0;
        while (busy && n < 5000) begin
            n++;
            @(negedge clk);
        end
        #1;
        chk(n == exp_n, tag, n, exp_n);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin : main
        // word 5: table at 20/21 -> W=0x140; 4 voiced periods, stop
        mem[20] = 'h20; mem[21] = 'h40;
        mem['h140] = 'h5E; mem['h141] = 'h30;
        // word 9: table at 36/37 -> W=0x280; 1 unvoiced period, then 2 voiced + stop
        mem[36] = 'h40; mem[37] = 'h80;
        mem['h280] = 'h20; mem['h281] = 'h10;
        mem['h282] = 'h2E; mem['h283] = 'hF0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
        chk(addr == '0, "R1 reset address", int'(addr), 0);
        chk(lvl == '0, "R1 reset level", int'(lvl), 0);
        repeat (5) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1 stays idle", int'(busy), 0);

        // R8: 5 fetch cycles + 4 periods of 128
        fire(5);
        count_busy(517, "R8 stop after four periods");
        // R8: 5 + 128 + 2 + 256, next control word at W+2 (R5)
        fire(9);
        count_busy(391, "R8 chained control words");

        // R2: start held for two cycles
        @(negedge clk);
        start = 1'b1; word = 6'd5;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(int'(addr) == 20, "R2 held start address", int'(addr), 20);
        count_busy(517, "R2 held start length");

        // R2: restart in the middle of play
        fire(5);
        repeat (200) @(negedge clk);
        start = 1'b1; word = 6'd9;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy && int'(addr) == 36, "R2 mid-play restart", int'(addr), 36);
        count_busy(391, "R2 restart run length");

        // R10: start on the final carry of a stop-flagged word
        fire(5);
        while (!(m_st == 6 && m_ppc == 127 && m_rep == 3)) @(negedge clk);
        start = 1'b1; word = 6'd9;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(busy == 1'b1, "R10 busy kept", int'(busy), 1);
        chk(int'(addr) == 36, "R10 restart address", int'(addr), 36);
        count_busy(391, "R10 restart run length");

        repeat (4) @(negedge clk);
        summary();
        $finish;
    end

endmodule